// File: doc/BRIEF.md
# Way-Partitioned Cache Victim Selector

This block picks the way to evict from one set of a set-associative cache when a refill needs room. A requester, which is either one of several cores or the shared pool of hardware agents, presents its identity and the per-way state of the target set: valid, dirty, locked and use bits. Each requester owns a programmable way mask. A 0 bit lets that requester evict from the way and a 1 bit fences the way off. The hardware agents share one mask of their own. The masks limit eviction only. Lookups elsewhere in the cache may still hit in any way, so nothing in this block gates hits.

The decision is combinational. Ways that are masked or locked drop out first. Among the ways that remain, an invalid way wins. Next comes the lowest-numbered way whose use bit is clear. If every remaining way has its use bit set, the block takes the lowest remaining way and returns a vector of use bits for the surrounding logic to clear. When no way is left, a no-victim flag rises. A small register port writes the masks and reads them back. A write that would leave no allowed way is refused and flagged.

Top module: `vs_victim_sel`

## Requirements
- R1: After reset every mask reads back as all zeros, so every way is allowed for every requester.
- R2: With `req_hw`=0, the victim is only ever a way whose bit is 0 in the mask of core `req_core`. A written mask takes effect from the cycle after the write.
- R3: With `req_hw`=1, the hardware-agent mask applies. That mask is addressed as selector value CORES (selectors 0..CORES-1 address the cores) and is separate from every core mask.
- R4: A write whose data is all ones is refused. The addressed mask keeps its old value and `cfg_err` is 1 for exactly the one cycle after the write edge.
- R5: A way whose lock bit is 1 is never chosen.
- R6: If any eligible way (allowed and unlocked) is invalid, the lowest-numbered such way is chosen.
- R7: Otherwise, the lowest-numbered eligible way whose use bit is 0 is chosen.
- R8: If every eligible way is valid with its use bit at 1, the lowest eligible way is chosen and `use_clr` equals the set of eligible ways. In every other case `use_clr` is zero.
- R9: With no eligible way, `no_victim` is 1 and both `victim_oh` and `use_clr` are zero. Otherwise `no_victim` is 0 and `victim_oh` is one-hot.
- R10: `victim_dirty` is 1 exactly when the chosen line is both valid and dirty.
- R11: A write to a selector above CORES is refused with `cfg_err` as in R4 and changes no mask. A read of such a selector returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_hw | input | 1 | Requester is a hardware agent |
| req_core | input | CORE_W | Core index when req_hw is 0 |
| line_valid | input | WAYS | Per-way valid bits of the set |
| line_dirty | input | WAYS | Per-way dirty bits |
| line_lock | input | WAYS | Per-way lock bits |
| line_use | input | WAYS | Per-way use bits |
| victim_oh | output | WAYS | One-hot chosen way, zero if none |
| no_victim | output | 1 | No way can be evicted |
| use_clr | output | WAYS | Use bits to clear on a sweep |
| victim_dirty | output | 1 | Chosen line needs writeback |
| cfg_wr_en | input | 1 | Mask write strobe |
| cfg_wr_sel | input | SEL_W | Mask selector for writes |
| cfg_wdata | input | WAYS | Mask write data |
| cfg_err | output | 1 | Previous write was refused |
| cfg_rd_sel | input | SEL_W | Mask selector for reads |
| cfg_rdata | output | WAYS | Read-back of the selected mask |

## Verification
The bench goes after the priority ladder. One case has an invalid way sitting above a clear-use way, which catches a design that checks use before validity. Another has all use bits set on the eligible ways, which catches a wrong victim or a `use_clr` that covers masked or locked ways. An all-ones write must leave the old mask in place; a design that stored it would then report `no_victim` for every request. Out-of-range selectors and the hardware mask are aimed at too, since a selector decode that aliased them would let one requester's mask leak into another's decisions.

// File: rtl/vs_pkg.sv
package vs_pkg;

    // Which rung of the priority ladder produced the victim
    typedef enum logic [1:0] {
        PICK_NONE    = 2'd0,
        PICK_INVALID = 2'd1,
        PICK_COLD    = 2'd2,
        PICK_SWEEP   = 2'd3
    } pick_rule_e;

    function automatic int unsigned sel_width(input int unsigned cores);
        return (cores + 1 > 1) ? $clog2(cores + 1) : 1;
    endfunction

    function automatic int unsigned core_width(input int unsigned cores);
        return (cores > 1) ? $clog2(cores) : 1;
    endfunction

endpackage

// File: rtl/vs_mask_bank.sv
module vs_mask_bank #(
    parameter int unsigned WAYS  = 16,
    parameter int unsigned CORES = 4,
    parameter int unsigned SEL_W = 3,
    parameter int unsigned CORE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [WAYS-1:0]   wr_data,
    output logic              err_q,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [WAYS-1:0]   rd_data,
    input  logic              req_hw,
    input  logic [CORE_W-1:0] req_core,
    output logic [WAYS-1:0]   req_mask
);
    localparam int unsigned ENTRIES = CORES + 1;  // last entry: hardware agents
    localparam int unsigned HW_IDX  = CORES;

    logic [WAYS-1:0] mask_q [ENTRIES];
    logic            wr_ok;
    logic            sel_in_range;

    assign sel_in_range = (32'(wr_sel) < ENTRIES);
    assign wr_ok        = wr_en && sel_in_range && !(&wr_data);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[e] <= '0;
            end else if (wr_ok && (32'(wr_sel) == e)) begin
                mask_q[e] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else begin
            err_q <= wr_en && !wr_ok;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (32'(rd_sel) == e) rd_data = mask_q[e];
        end
    end

    // Core indices beyond CORES (non power-of-two counts) see every way fenced
    always_comb begin
        req_mask = '1;
        if (req_hw) begin
            req_mask = mask_q[HW_IDX];
        end else begin
            for (int c = 0; c < CORES; c++) begin
                if (32'(req_core) == c) req_mask = mask_q[c];
            end
        end
    end

endmodule

// File: rtl/vs_pick.sv
module vs_pick
    import vs_pkg::*;
#(
    parameter int unsigned WAYS = 16
) (
    input  logic [WAYS-1:0] fence,
    input  logic [WAYS-1:0] valid,
    input  logic [WAYS-1:0] dirty,
    input  logic [WAYS-1:0] lock,
    input  logic [WAYS-1:0] use_bits,
    output logic [WAYS-1:0] victim,
    output logic [WAYS-1:0] use_clr,
    output logic            none,
    output logic            victim_dirty,
    output pick_rule_e      rule
);
    logic [WAYS-1:0] eligible;
    logic [WAYS-1:0] empty_ways;
    logic [WAYS-1:0] cold_ways;

    assign eligible   = ~fence & ~lock;
    assign empty_ways = eligible & ~valid;
    assign cold_ways  = eligible & valid & ~use_bits;

    always_comb begin
        victim  = '0;
        use_clr = '0;
        rule    = PICK_NONE;
        if (|empty_ways) begin
            victim = empty_ways & (~empty_ways + 1'b1);
            rule   = PICK_INVALID;
        end else if (|cold_ways) begin
            victim = cold_ways & (~cold_ways + 1'b1);
            rule   = PICK_COLD;
        end else if (|eligible) begin
            victim  = eligible & (~eligible + 1'b1);
            use_clr = eligible;
            rule    = PICK_SWEEP;
        end
    end

    assign none         = (rule == PICK_NONE);
    assign victim_dirty = |(victim & valid & dirty);

endmodule

// File: rtl/vs_victim_sel.sv
module vs_victim_sel
    import vs_pkg::*;
#(
    parameter int unsigned WAYS   = 16,
    parameter int unsigned CORES  = 4,
    parameter int unsigned SEL_W  = sel_width(CORES),
    parameter int unsigned CORE_W = core_width(CORES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_hw,
    input  logic [CORE_W-1:0] req_core,
    input  logic [WAYS-1:0]   line_valid,
    input  logic [WAYS-1:0]   line_dirty,
    input  logic [WAYS-1:0]   line_lock,
    input  logic [WAYS-1:0]   line_use,
    output logic [WAYS-1:0]   victim_oh,
    output logic              no_victim,
    output logic [WAYS-1:0]   use_clr,
    output logic              victim_dirty,
    input  logic              cfg_wr_en,
    input  logic [SEL_W-1:0]  cfg_wr_sel,
    input  logic [WAYS-1:0]   cfg_wdata,
    output logic              cfg_err,
    input  logic [SEL_W-1:0]  cfg_rd_sel,
    output logic [WAYS-1:0]   cfg_rdata
);
    logic [WAYS-1:0] active_mask;
    pick_rule_e      rule;

    vs_mask_bank #(
        .WAYS(WAYS), .CORES(CORES), .SEL_W(SEL_W), .CORE_W(CORE_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wdata),
        .err_q    (cfg_err),
        .rd_sel   (cfg_rd_sel),
        .rd_data  (cfg_rdata),
        .req_hw   (req_hw),
        .req_core (req_core),
        .req_mask (active_mask)
    );

    vs_pick #(.WAYS(WAYS)) u_pick (
        .fence        (active_mask),
        .valid        (line_valid),
        .dirty        (line_dirty),
        .lock         (line_lock),
        .use_bits     (line_use),
        .victim       (victim_oh),
        .use_clr      (use_clr),
        .none         (no_victim),
        .victim_dirty (victim_dirty),
        .rule         (rule)
    );

endmodule

// File: rtl/vs_victim_sel_chk.sv
module vs_victim_sel_chk #(
    parameter int unsigned WAYS   = 16,
    parameter int unsigned CORES  = 4,
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned CORE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [WAYS-1:0]   line_valid,
    input logic [WAYS-1:0]   line_lock,
    input logic [WAYS-1:0]   victim_oh,
    input logic              no_victim,
    input logic [WAYS-1:0]   use_clr,
    input logic              cfg_wr_en,
    input logic [SEL_W-1:0]  cfg_wr_sel,
    input logic [WAYS-1:0]   cfg_wdata,
    input logic              cfg_err,
    input logic [SEL_W-1:0]  cfg_rd_sel,
    input logic [WAYS-1:0]   cfg_rdata
);
    p_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(victim_oh) && (no_victim == (victim_oh == '0)));

    p_never_locked_r5: assert property (@(posedge clk) disable iff (rst)
        (victim_oh & line_lock) == '0);

    p_sweep_covers_victim_r8: assert property (@(posedge clk) disable iff (rst)
        (use_clr != '0) |-> (((victim_oh & use_clr) == victim_oh) && !no_victim));

    p_clr_excludes_locked_r8: assert property (@(posedge clk) disable iff (rst)
        (use_clr & line_lock) == '0);

    p_reject_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && (&cfg_wdata)) |=> cfg_err);

    p_reject_keeps_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_en && (&cfg_wdata) && (cfg_wr_sel == cfg_rd_sel)) |=>
            ($stable(cfg_rd_sel) -> $stable(cfg_rdata)));

    p_no_err_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !cfg_wr_en |=> !cfg_err);

    p_range_read_r11: assert property (@(posedge clk) disable iff (rst)
        (32'(cfg_rd_sel) > CORES) |-> (cfg_rdata == '0));

endmodule

bind vs_victim_sel vs_victim_sel_chk #(
    .WAYS(WAYS), .CORES(CORES), .SEL_W(SEL_W), .CORE_W(CORE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line_valid (line_valid),
    .line_lock  (line_lock),
    .victim_oh  (victim_oh),
    .no_victim  (no_victim),
    .use_clr    (use_clr),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_wr_sel (cfg_wr_sel),
    .cfg_wdata  (cfg_wdata),
    .cfg_err    (cfg_err),
    .cfg_rd_sel (cfg_rd_sel),
    .cfg_rdata  (cfg_rdata)
);

// File: tb/tb_vs_victim_sel.sv
`timescale 1ns/1ps
module tb_vs_victim_sel;
    localparam int W = 16;
    localparam int NC = 4;
    localparam int SW = 3;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;  // 250 MHz

    logic          req_hw;
    logic [CW-1:0] req_core;
    logic [W-1:0]  line_valid, line_dirty, line_lock, line_use;
    logic [W-1:0]  victim_oh, use_clr, cfg_wdata, cfg_rdata;
    logic          no_victim, victim_dirty, cfg_wr_en, cfg_err;
    logic [SW-1:0] cfg_wr_sel, cfg_rd_sel;

    vs_victim_sel #(.WAYS(W), .CORES(NC)) dut (
        .clk(clk), .rst(rst), .req_hw(req_hw), .req_core(req_core),
        .line_valid(line_valid), .line_dirty(line_dirty), .line_lock(line_lock),
        .line_use(line_use), .victim_oh(victim_oh), .no_victim(no_victim),
        .use_clr(use_clr), .victim_dirty(victim_dirty), .cfg_wr_en(cfg_wr_en),
        .cfg_wr_sel(cfg_wr_sel), .cfg_wdata(cfg_wdata), .cfg_err(cfg_err),
        .cfg_rd_sel(cfg_rd_sel), .cfg_rdata(cfg_rdata)
    );

    // Stimulus staged by the test sequence, applied by tick()
    bit            s_hw, s_wr;
    int            s_core, s_wsel, s_rsel;
    logic [W-1:0]  s_val, s_dty, s_lck, s_use, s_wd;

    // Reference state
    logic [W-1:0]  m_mask [0:NC];
    bit            m_err;
    int            n_chk, n_fail;
    bit            done;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic [W-1:0] fence, elig, pool, e_vic, e_clr;
        bit           e_none, e_dty;
        string        rtag;
        @(negedge clk);
        req_hw = s_hw; req_core = CW'(s_core);
        line_valid = s_val; line_dirty = s_dty; line_lock = s_lck; line_use = s_use;
        cfg_wr_en = s_wr; cfg_wr_sel = SW'(s_wsel); cfg_wdata = s_wd; cfg_rd_sel = SW'(s_rsel);
        #1;
        fence = s_hw ? m_mask[NC] : m_mask[s_core];
        elig  = ~fence & ~s_lck;
        e_vic = '0; e_clr = '0; e_none = 1'b0; rtag = "R9";
        pool  = elig & ~s_val;
        if (pool != 0) rtag = "R6";
        else begin
            pool = elig & ~s_use;
            if (pool != 0) rtag = "R7";
            else if (elig != 0) begin pool = elig; e_clr = elig; rtag = "R8"; end
            else e_none = 1'b1;
        end
        for (int i = W - 1; i >= 0; i--) if (pool[i]) e_vic = W'(1) << i;
        e_dty = |(e_vic & s_val & s_dty);
        check({rtag, " victim R2 R3 R5"}, victim_oh, e_vic);
        check("R9 no_victim", W'(no_victim), W'(e_none));
        check("R8 use_clr", use_clr, e_clr);
        check("R10 victim_dirty", W'(victim_dirty), W'(e_dty));
        check("R4 R11 cfg_err", W'(cfg_err), W'(m_err));
        check("R1 R11 cfg_rdata", cfg_rdata, (s_rsel <= NC) ? m_mask[s_rsel] : '0);
        // model update for the coming edge
        if (s_wr) begin
            if (s_wsel <= NC && !(&s_wd)) begin m_mask[s_wsel] = s_wd; m_err = 1'b0; end
            else m_err = 1'b1;
        end else m_err = 1'b0;
        s_wr = 1'b0;
    endtask

    task automatic wr(input int sel, input logic [W-1:0] d);
        s_wr = 1'b1; s_wsel = sel; s_wd = d; tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e <= NC; e++) m_mask[e] = '0;
        m_err = 0; n_chk = 0; n_fail = 0; done = 0;
        s_hw = 0; s_core = 0; s_wr = 0; s_wsel = 0; s_rsel = 0; s_wd = '0;
        s_val = '1; s_dty = '0; s_lck = '0; s_use = '1;
        req_hw = 0; req_core = '0; line_valid = '1; line_dirty = '0; line_lock = '0;
        line_use = '1; cfg_wr_en = 0; cfg_wr_sel = '0; cfg_wdata = '0; cfg_rd_sel = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R1: every mask, including hardware, reads zero after reset
        for (int e = 0; e < 8; e++) begin s_rsel = e; tick(); end
        // R6: invalid way above a cold way still wins
        s_val = 16'hFFDF; s_use = 16'hFFFB; tick();
        // R7: lowest cold way; R10 dirty victim
        s_val = '1; s_use = 16'hFF0F; s_dty = 16'h0010; tick();
        // R8: sweep with locks in low ways
        s_use = '1; s_lck = 16'h0003; tick();
        // R2: core 1 fences low byte; R4 refused all-ones write to core 1
        wr(1, 16'h00FF);
        s_core = 1; s_rsel = 1; tick();
        wr(1, 16'hFFFF);
        tick();
        // R3: hardware mask separate from cores
        wr(NC, 16'hFFFE); s_hw = 1; s_rsel = NC; s_lck = '0; tick();
        s_lck = 16'h0001; tick();           // R9: only allowed way locked
        s_hw = 0; s_core = 0; tick();
        // R11: out-of-range write refused
        wr(6, 16'h0001); s_rsel = 6; tick();
        // random sweep
        for (int k = 0; k < 3000; k++) begin
            s_hw = ($urandom_range(0, 3) == 0); s_core = $urandom_range(0, NC - 1);
            s_val = W'($urandom) | W'($urandom); s_use = W'($urandom) | W'($urandom);
            s_dty = W'($urandom);
            s_lck = ($urandom_range(0, 5) == 0) ? W'($urandom) | W'($urandom) : W'($urandom) & W'($urandom) & W'($urandom);
            s_rsel = $urandom_range(0, 7);
            if ($urandom_range(0, 4) == 0) begin
                s_wr = 1; s_wsel = $urandom_range(0, 6);
                s_wd = ($urandom_range(0, 3) == 0) ? '1 : W'($urandom);
            end
            tick();
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule